// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block gathers up to 63 level-sensitive interrupt requests, numbered 1 to 63, and offers the CPU the most urgent one. Each request passes only when its mask bit is clear, the global mask-all bit is clear, and it has a non-zero level. The CPU sees the winner as a 3-bit level and an 8-bit vector. An acknowledge pulse freezes the presented vector into a response register for exactly one cycle.

Software sets up the block through a small register port. Two 32-bit words hold one mask bit per source. Bit 0 of the low word is not a source: it blocks every request while it is set. Each programmable source has a control byte. Bits [5:3] of that byte set its level and bits [2:0] set its rank inside the level. Sources 1 to 7 are external lines whose level is wired to their own number.

Top module: `vic_core`

## Requirements
- R1: After reset both mask words read 0xFFFF_FFFF, every programmable control byte reads 0, `irq_level` is 0, `irq_vec` equals VEC_BASE and `ack_valid` is 0.
- R2: Source n is gated by mask bit n[4:0] of the high word (address 0x04) when n[5] is 1, and of the low word (address 0x00) otherwise. A 1 blocks the source and a 0 lets it through.
- R3: While bit 0 of the low mask word is 1, `irq_level` is 0 one cycle later, whatever the other bits and requests are. Writing 0x1 to the low word alone therefore keeps everything blocked.
- R4: Control byte bits [5:3] are the level and bits [2:0] are the priority. A source whose level field is 0 (this includes a byte of 0) is never forwarded.
- R5: Sources 1 to 7 have a fixed level equal to n and a priority of 0. Their control bytes read {2'b00, n[2:0], 3'b000}, and writes to them are ignored.
- R6: Among the qualifying sources, the highest level wins. A tie on level goes to the higher priority value. A remaining tie goes to the lower source number.
- R7: `irq_level` and `irq_vec` are registered. One clock after the inputs and registers settle, they show the winner's level and VEC_BASE plus its number. When nothing qualifies, they show level 0 and VEC_BASE.
- R8: When `iack` is high at a clock edge, `ack_valid` is 1 for the next cycle only, and `ack_vec` holds the `irq_vec` value that was present at that edge.
- R9: `rdata` is combinational from `addr`. 0x00 is the low mask, 0x04 is the high mask, and 0x40+n (n = 1..63) is the control byte of source n, zero-extended. Every other address reads 0. A write at 0x40+n with n > 7 loads `wdata[7:0]` into that control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 64 | Level request per source, bit n is source n, bit 0 unused |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_level | output | 3 | Level of the presented request, 0 when none |
| irq_vec | output | 8 | Vector of the presented request |
| iack | input | 1 | Interrupt acknowledge |
| ack_valid | output | 1 | Acknowledge response valid, one cycle |
| ack_vec | output | 8 | Vector returned for the acknowledge |

## Verification
The bench first lifts the mask words and writes 0x1 to the low word. A design that treated bit 0 as an ordinary source, or that ignored it, would forward the fixed external lines at that point. It programs a byte with level 0 but a non-zero priority, which catches a design that only tests for a zero byte. It then builds ties on level and on priority, where a reversed comparison or a scan that keeps the last match would pick the wrong vector. It also masks a high-word source, where a wrong word select would leave that source live. Finally it checks that writes to the fixed sources' bytes are lost, and that the acknowledge response lasts exactly one cycle.

// File: rtl/vic_core.sv
module vic_core #(
  parameter int SRC_COUNT   = 63,
  parameter int FIXED_COUNT = 7,
  parameter logic [7:0] VEC_BASE = 8'd64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_COUNT:0]   src_req,
  input  logic                 wr_en,
  input  logic [6:0]           addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [2:0]           irq_level,
  output logic [7:0]           irq_vec,
  input  logic                 iack,
  output logic                 ack_valid,
  output logic [7:0]           ack_vec
);
  localparam int SW = SRC_COUNT + 1;
  localparam int IW = $clog2(SW);

  logic [31:0] mask_lo, mask_hi;
  logic [63:0] mask_all_bits;
  logic [7:0]  ctrl_q   [FIXED_COUNT+1:SW-1];
  logic [7:0]  ctrl_eff [SW];
  logic [SW-1:0] qual;
  logic [5:0]  best_key;
  logic [IW-1:0] best_idx;
  logic        ctrl_win;

  assign mask_all_bits = {mask_hi, mask_lo};
  assign ctrl_win = addr[6];

  for (genvar g = 0; g < SW; g++) begin : g_src
    if (g == 0) begin : g_none
      assign ctrl_eff[g] = 8'd0;
      assign qual[g] = 1'b0;
    end else begin : g_real
      if (g <= FIXED_COUNT) begin : g_fixed
        assign ctrl_eff[g] = {2'b00, 3'(g), 3'b000};
      end else begin : g_prog
        always_ff @(posedge clk) begin
          if (!rst_n)
            ctrl_q[g] <= 8'd0;
          else if (wr_en && ctrl_win && addr[5:0] == 6'(g))
            ctrl_q[g] <= wdata[7:0];
        end
        assign ctrl_eff[g] = ctrl_q[g];
      end
      assign qual[g] = src_req[g] && !mask_all_bits[g] && !mask_lo[0]
                       && (ctrl_eff[g][5:3] != 3'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_lo <= '1;
      mask_hi <= '1;
    end else if (wr_en && !ctrl_win) begin
      if (addr == 7'h00) mask_lo <= wdata;
      if (addr == 7'h04) mask_hi <= wdata;
    end
  end

  always_comb begin
    best_key = 6'd0;
    best_idx = '0;
    for (int n = 1; n < SW; n++) begin
      if (qual[n] && ctrl_eff[n][5:0] > best_key) begin
        best_key = ctrl_eff[n][5:0];
        best_idx = IW'(n);
      end
    end
  end

  always_comb begin
    rdata = 32'd0;
    if (ctrl_win)
      rdata = {24'd0, ctrl_eff[addr[5:0]]};
    else if (addr == 7'h00)
      rdata = mask_lo;
    else if (addr == 7'h04)
      rdata = mask_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_level <= 3'd0;
      irq_vec   <= VEC_BASE;
      ack_valid <= 1'b0;
      ack_vec   <= VEC_BASE;
    end else begin
      irq_level <= best_key[5:3];
      irq_vec   <= VEC_BASE + 8'(best_idx);
      ack_valid <= iack;
      if (iack) ack_vec <= irq_vec;
    end
  end
endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk #(
  parameter logic [7:0] VEC_BASE = 8'd64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mask_all,
  input logic       iack,
  input logic [2:0] irq_level,
  input logic [7:0] irq_vec,
  input logic       ack_valid,
  input logic [7:0] ack_vec
);
  assert_maskall_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all |=> irq_level == 3'd0);

  assert_idle_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == 3'd0 |-> irq_vec == VEC_BASE);

  assert_ack_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> ack_valid);

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !iack |=> !ack_valid);

  assert_ack_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> ack_vec == $past(irq_vec));
endmodule

bind vic_core vic_core_chk #(.VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_all(mask_lo[0]), .iack(iack),
  .irq_level(irq_level), .irq_vec(irq_vec),
  .ack_valid(ack_valid), .ack_vec(ack_vec)
);

// File: tb/tb_vic_core.sv
module tb_vic_core;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] src_req = '0;
  logic        wr_en = 0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vec;
  logic        iack = 0;
  logic        ack_valid;
  logic [7:0]  ack_vec;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [2:0] lvl; logic [7:0] vec; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  vic_core dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_level(irq_level), .irq_vec(irq_vec),
    .iack(iack), .ack_valid(ack_valid), .ack_vec(ack_vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string tag, input logic [6:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 check(tag, rdata, exp);
  endtask

  task automatic expect_irq(input string tag, input logic [2:0] lvl, input logic [7:0] vec);
    sb.push_back('{lvl, vec, tag});
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #3;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " level"}, 32'(irq_level), 32'(e.lvl));
        check({e.tag, " vector"}, 32'(irq_vec), 32'(e.vec));
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 level", 32'(irq_level), 0);
    check("R1 vector", 32'(irq_vec), 64);
    check("R1 ack_valid", 32'(ack_valid), 0);
    rd("R1 mask low", 7'h00, 32'hFFFF_FFFF);
    rd("R1 mask high", 7'h04, 32'hFFFF_FFFF);
    rd("R1 ctrl 10", 7'h40 + 7'd10, 0);
    // R5 fixed source bytes
    rd("R5 ctrl 3", 7'h43, 32'h18);
    wr(7'h43, 32'hFF);
    rd("R5 ctrl 3 after write", 7'h43, 32'h18);
    rd("R5 ctrl 7", 7'h47, 32'h38);
    // R3 mask-all with everything else open
    src_req = '1;
    src_req[0] = 1'b0;
    wr(7'h04, 32'h0);
    wr(7'h00, 32'h1);
    expect_irq("R3 mask-all only", 0, 64);
    expect_irq("R3 mask-all held", 0, 64);
    // R4 level-zero sources never forwarded
    wr(7'h00, 32'hFFFF_FFFE);
    expect_irq("R4 zero bytes", 0, 64);
    wr(7'h40 + 7'd40, 32'h07);
    expect_irq("R4 level field zero", 0, 64);
    wr(7'h40 + 7'd40, 32'h2A);
    expect_irq("R7 single source 40", 5, 104);
    // R6 arbitration
    wr(7'h40 + 7'd50, 32'h2D);
    expect_irq("R6 higher priority 50", 5, 114);
    wr(7'h40 + 7'd45, 32'h2D);
    expect_irq("R6 tie lower number 45", 5, 109);
    wr(7'h40 + 7'd60, 32'h30);
    expect_irq("R6 higher level 60", 6, 124);
    // R2 high word mask of source 60
    wr(7'h04, 32'h1000_0000);
    expect_irq("R2 high mask bit 28", 5, 109);
    rd("R9 mask high read", 7'h04, 32'h1000_0000);
    // R2 low word: open fixed source 7
    wr(7'h00, 32'hFFFF_FF7E);
    expect_irq("R2 low unmask 7", 7, 71);
    wr(7'h40 + 7'd33, 32'h3F);
    expect_irq("R6 level 7 prio 7 beats fixed 7", 7, 97);
    src_req[33] = 1'b0;
    expect_irq("R7 request drop falls back to 7", 7, 71);
    // R8 acknowledge
    @(negedge clk);
    iack = 1;
    @(negedge clk);
    iack = 0;
    check("R8 ack_valid high", 32'(ack_valid), 1);
    check("R8 ack vector", 32'(ack_vec), 71);
    @(negedge clk);
    check("R8 ack_valid one cycle", 32'(ack_valid), 0);
    // R3 writing 0x1 to low word
    wr(7'h00, 32'h1);
    expect_irq("R3 low word 0x1", 0, 64);
    src_req = '0;
    wr(7'h00, 32'h0);
    expect_irq("R7 no requests", 0, 64);
    // R9 reads
    rd("R9 unmapped", 7'h10, 0);
    rd("R9 ctrl 45", 7'h40 + 7'd45, 32'h2D);
    rd("R9 ctrl 0 slot", 7'h40, 0);
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule